// File: doc/BRIEF.md
# NOR Flash Buffered Program Sequencer

This block drives one buffered-program operation on a parallel NOR flash with a 16-bit data path. A request carries a halfword start address and a word count; once accepted, the sequencer issues the two unlock writes, the buffer-load command, the count word and the data writes, and then the confirm write that starts the device's internal program cycle. Data words arrive on a valid/ready stream and are written to consecutive halfword addresses. Polling the device for completion is left to a separate status block, which can begin as soon as the completion pulse appears.

Every bus write holds the write strobe for `WR_CYC` clocks with a steady address and data. The next write follows with no idle cycle unless the data stream has no word ready. Requests that would overrun the device page buffer are refused before any bus activity. A refused request is a zero count, a count above `MAX_WORDS`, or a run that crosses a `MAX_WORDS`-aligned boundary. All addresses are halfword addresses relative to the flash base.

States: `S_IDLE` waits for `start`. From there, `IDLE->UNLK1` is taken for a valid request and `IDLE->REJ` for an invalid one. The writes run `UNLK1->UNLK2->LOAD->COUNT`, each step taken on the last strobe cycle. `COUNT->DATA` is taken when a word is taken on that last cycle, and `COUNT->DWAIT` otherwise. `DWAIT->DATA` is taken when a word is taken. `DATA->DATA` follows a taken word, `DATA->DWAIT` follows no word, and `DATA->CONF` follows the final word. After that come `CONF->FIN` on the last strobe cycle, then `FIN->IDLE` and `REJ->IDLE` after one clock each.

Top module: `nor_wrbuf_seq`

## Requirements
- R1: An accepted operation begins with data 0x00AA written to address 0x555, followed by data 0x0055 written to address 0x2AA.
- R2: After the unlock pair, data 0x0025 is written to the start address, and then the value count-1 is written to the start address.
- R3: The data words are written in stream order, word i going to address start+i, for i from 0 to count-1.
- R4: The final write of an operation puts data 0x0029 at address start+count-1, and no other bus write belongs to the operation.
- R5: Each bus write keeps `bus_we` high for exactly `WR_CYC` consecutive clocks with stable `bus_addr` and `bus_data`. When the stream always has a word, all count+5 writes are back to back, the first one starting the clock after `start` is sampled.
- R6: A data word is taken only on a clock where both `data_valid` and `data_ready` are high. If a clock has `data_ready` high and `data_valid` low, the next clock has `bus_we` low.
- R7: A request with count 0, with count above `MAX_WORDS`, or with (start mod `MAX_WORDS`) + count above `MAX_WORDS` produces a one-clock `err` pulse in the clock after `start` and no bus write.
- R8: `done` is high for exactly one clock, the clock right after the last strobe cycle of the confirm write. `busy` is high from the clock after an accepted `start` through the `done` clock, and low after it.
- R9: `start` is ignored while `busy` is high. The latched address and count stay in use even if the request inputs change.
- R10: After reset, `busy`, `bus_we`, `data_ready`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, sampled while idle |
| start_addr | input | ADDR_W | Halfword address of the first data word |
| word_count | input | CNT_W | Number of data words, 1 to MAX_WORDS |
| data_valid | input | 1 | Data word available |
| data_word | input | DATA_W | Data word to program |
| data_ready | output | 1 | Sequencer takes the word on this clock if valid |
| bus_we | output | 1 | Flash write strobe, held WR_CYC clocks per write |
| bus_addr | output | ADDR_W | Flash halfword address |
| bus_data | output | DATA_W | Flash write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock pulse after the confirm write |
| err | output | 1 | One-clock pulse for a refused request |

## Verification
The bench tries several request patterns. A four-word run with an always-valid stream checks the command order and the back-to-back timing. A single word at the last offset of a buffer window separates the count-1 and confirm addresses from the start address only by their values. A full 32-word window shows the count field and address increments at their limit. A run with gaps in the data stream shows that stalls drop the strobe without losing or reordering words. Three refused requests (count zero, count too large, and a window crossing) are set against an accepted run that ends exactly on the window edge. A second `start` with different arguments in the middle of a run shows whether the latched request survives.

// File: rtl/nor_wrbuf_pkg.sv
package nor_wrbuf_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_UNLK1,
        S_UNLK2,
        S_LOAD,
        S_COUNT,
        S_DWAIT,
        S_DATA,
        S_CONF,
        S_FIN,
        S_REJ
    } seq_state_e;

    localparam logic [11:0] UNLK1_ADDR = 12'h555;
    localparam logic [11:0] UNLK2_ADDR = 12'h2AA;
    localparam logic [7:0]  UNLK1_CODE = 8'hAA;
    localparam logic [7:0]  UNLK2_CODE = 8'h55;
    localparam logic [7:0]  LOAD_CODE  = 8'h25;
    localparam logic [7:0]  CONF_CODE  = 8'h29;

endpackage

// File: rtl/nor_wrbuf_rangechk.sv
module nor_wrbuf_rangechk #(
    parameter int MAX_WORDS = 32,
    parameter int CNT_W     = $clog2(MAX_WORDS + 1),
    parameter int OFF_W     = $clog2(MAX_WORDS)
) (
    input  logic [OFF_W-1:0] win_offset,
    input  logic [CNT_W-1:0] word_count,
    output logic             req_ok
);
    localparam int SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] span;

    always_comb begin
        span   = SUM_W'(win_offset) + SUM_W'(word_count);
        req_ok = (word_count != '0)
              && (SUM_W'(word_count) <= SUM_W'(MAX_WORDS))
              && (span <= SUM_W'(MAX_WORDS));
    end
endmodule

// File: rtl/nor_wrbuf_timer.sv
module nor_wrbuf_timer #(
    parameter int WR_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    output logic last
);
    generate
        if (WR_CYC == 1) begin : g_single
            assign last = we;
        end else begin : g_count
            localparam int TW = $clog2(WR_CYC + 1);
            logic [TW-1:0] cyc_q;

            assign last = we && (cyc_q == TW'(WR_CYC - 1));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cyc_q <= '0;
                else if (!we || last)
                    cyc_q <= '0;
                else
                    cyc_q <= cyc_q + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/nor_wrbuf_seq.sv
module nor_wrbuf_seq
    import nor_wrbuf_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 16,
    parameter int MAX_WORDS = 32,
    parameter int WR_CYC    = 2,
    localparam int CNT_W    = $clog2(MAX_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  word_count,
    input  logic              data_valid,
    input  logic [DATA_W-1:0] data_word,
    output logic              data_ready,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int OFF_W = $clog2(MAX_WORDS);

    seq_state_e        state, nxt;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  idx_q;
    logic [DATA_W-1:0] word_q;
    logic [CNT_W-1:0]  cnt_m1;
    logic              req_ok;
    logic              wr_last;
    logic              last_word;
    logic              take;

    nor_wrbuf_rangechk #(
        .MAX_WORDS (MAX_WORDS),
        .CNT_W     (CNT_W),
        .OFF_W     (OFF_W)
    ) u_range (
        .win_offset (start_addr[OFF_W-1:0]),
        .word_count (word_count),
        .req_ok     (req_ok)
    );

    nor_wrbuf_timer #(
        .WR_CYC (WR_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_we),
        .last  (wr_last)
    );

    assign cnt_m1    = cnt_q - 1'b1;
    assign last_word = (idx_q == cnt_m1);
    assign take      = data_ready && data_valid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    // Latched request, word index and held data word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            idx_q  <= '0;
            word_q <= '0;
        end else begin
            if (state == S_IDLE && start) begin
                base_q <= start_addr;
                cnt_q  <= word_count;
            end
            if (state == S_LOAD)
                idx_q <= '0;
            else if (state == S_DATA && wr_last)
                idx_q <= idx_q + 1'b1;
            if (take)
                word_q <= data_word;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = req_ok ? S_UNLK1 : S_REJ;
            S_UNLK1: if (wr_last) nxt = S_UNLK2;
            S_UNLK2: if (wr_last) nxt = S_LOAD;
            S_LOAD:  if (wr_last) nxt = S_COUNT;
            S_COUNT: if (wr_last) nxt = take ? S_DATA : S_DWAIT;
            S_DWAIT: if (take) nxt = S_DATA;
            S_DATA:  if (wr_last) nxt = last_word ? S_CONF : (take ? S_DATA : S_DWAIT);
            S_CONF:  if (wr_last) nxt = S_FIN;
            S_FIN:   nxt = S_IDLE;
            S_REJ:   nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        bus_we     = 1'b0;
        bus_addr   = '0;
        bus_data   = '0;
        data_ready = 1'b0;
        busy       = (state != S_IDLE);
        done       = (state == S_FIN);
        err        = (state == S_REJ);
        unique case (state)
            S_UNLK1: begin
                bus_we   = 1'b1;
                bus_addr = ADDR_W'(UNLK1_ADDR);
                bus_data = DATA_W'(UNLK1_CODE);
            end
            S_UNLK2: begin
                bus_we   = 1'b1;
                bus_addr = ADDR_W'(UNLK2_ADDR);
                bus_data = DATA_W'(UNLK2_CODE);
            end
            S_LOAD: begin
                bus_we   = 1'b1;
                bus_addr = base_q;
                bus_data = DATA_W'(LOAD_CODE);
            end
            S_COUNT: begin
                bus_we     = 1'b1;
                bus_addr   = base_q;
                bus_data   = DATA_W'(cnt_m1);
                data_ready = wr_last;
            end
            S_DWAIT: data_ready = 1'b1;
            S_DATA: begin
                bus_we     = 1'b1;
                bus_addr   = base_q + ADDR_W'(idx_q);
                bus_data   = word_q;
                data_ready = wr_last && !last_word;
            end
            S_CONF: begin
                bus_we   = 1'b1;
                bus_addr = base_q + ADDR_W'(cnt_m1);
                bus_data = DATA_W'(CONF_CODE);
            end
            S_IDLE, S_FIN, S_REJ: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/nor_wrbuf_sva.sv
module nor_wrbuf_sva #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int WR_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_data,
    input logic              data_ready,
    input logic              busy,
    input logic              done,
    input logic              err
);
    localparam int TW = $clog2(WR_CYC + 1);

    logic [TW-1:0] wc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wc <= '0;
        else if (bus_we && (wc != TW'(WR_CYC - 1)))
            wc <= wc + 1'b1;
        else
            wc <= '0;
    end

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wc != '0) |-> bus_we);

    p_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && wc != '0) |-> ($stable(bus_addr) && $stable(bus_data)));

    p_done_after_confirm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(bus_we) && $past(bus_data) == DATA_W'(8'h29)));

    p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err}));

    p_reject_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!bus_we && !data_ready));

    p_ready_in_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |-> (busy && !done && !err));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_we && !data_ready && !done));
endmodule

bind nor_wrbuf_seq nor_wrbuf_sva #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WR_CYC (WR_CYC)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_data   (bus_data),
    .data_ready (data_ready),
    .busy       (busy),
    .done       (done),
    .err        (err)
);

// File: tb/nor_wrbuf_seq_bench.sv
module nor_wrbuf_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 24;
    localparam int DATA_W     = 16;
    localparam int MAX_WORDS  = 32;
    localparam int WR_CYC     = 2;
    localparam int CNT_W      = $clog2(MAX_WORDS + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [CNT_W-1:0]  word_count = '0;
    logic              data_valid = 1'b0;
    logic [DATA_W-1:0] data_word = '0;
    logic              data_ready, bus_we, busy, done, err;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_data;

    nor_wrbuf_seq #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W),
        .MAX_WORDS (MAX_WORDS), .WR_CYC (WR_CYC)
    ) u_nor_wrbuf_seq (
        .clk (clk), .rst_n (rst_n), .start (start), .start_addr (start_addr),
        .word_count (word_count), .data_valid (data_valid), .data_word (data_word),
        .data_ready (data_ready), .bus_we (bus_we), .bus_addr (bus_addr),
        .bus_data (bus_data), .busy (busy), .done (done), .err (err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Scoreboard queues
    logic [ADDR_W+DATA_W-1:0] exp_q[$];
    string                    tag_q[$];

    // Monitor state
    int wcnt = 0;
    int we_cycles = 0;
    int first_we_cyc = -1;
    int last_we_cyc = -1;
    int err_cnt = 0;
    int err_cyc = -1;
    bit stall_prev = 1'b0;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_data;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (stall_prev)
                chk(!bus_we, "R6", "strobe after stalled ready", longint'(bus_we), 0);
            stall_prev = data_ready && !data_valid;
            if (bus_we) begin
                if (we_cycles == 0) first_we_cyc = cyc;
                we_cycles++;
                last_we_cyc = cyc;
                if (wcnt == 0) begin
                    cur_addr = bus_addr;
                    cur_data = bus_data;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R4", "unexpected write addr", longint'(bus_addr), 0);
                    end else begin
                        logic [ADDR_W+DATA_W-1:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        chk(bus_addr == e[ADDR_W+DATA_W-1:DATA_W], t, "write address",
                            longint'(bus_addr), longint'(e[ADDR_W+DATA_W-1:DATA_W]));
                        chk(bus_data == e[DATA_W-1:0], t, "write data",
                            longint'(bus_data), longint'(e[DATA_W-1:0]));
                    end
                end else begin
                    chk(bus_addr == cur_addr && bus_data == cur_data, "R5",
                        "address/data held", longint'(bus_addr), longint'(cur_addr));
                end
                wcnt = (wcnt + 1 == WR_CYC) ? 0 : wcnt + 1;
            end else if (wcnt != 0) begin
                chk(1'b0, "R5", "strobe shortened at beat", longint'(wcnt), WR_CYC);
                wcnt = 0;
            end
            if (done)
                chk(cyc == last_we_cyc + 1, "R8", "done cycle", cyc, last_we_cyc + 1);
            if (err) begin
                err_cnt++;
                err_cyc = cyc;
            end
        end
    end

    function automatic logic [DATA_W-1:0] wgen(input int seed, input int i);
        return DATA_W'((seed * 977 + i * 313) ^ 16'hA5A5);
    endfunction

    function automatic void push(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                                 input string t);
        exp_q.push_back({a, d});
        tag_q.push_back(t);
    endfunction

    task automatic feed(input int n, input int gap, input int seed);
        for (int i = 0; i < n; i++) begin
            bit acc;
            if (gap > 0 && i > 0) begin
                data_valid = 1'b0;
                repeat (gap) @(negedge clk);
            end
            data_valid = 1'b1;
            data_word  = wgen(seed, i);
            acc = 1'b0;
            while (!acc) begin
                acc = data_ready;
                @(negedge clk);
            end
        end
        data_valid = 1'b0;
    endtask

    task automatic reset_mon();
        we_cycles = 0;
        first_we_cyc = -1;
        err_cnt = 0;
        err_cyc = -1;
    endtask

    task automatic run_seq(input logic [ADDR_W-1:0] a, input int n, input int gap,
                           input bit poke, input int seed);
        int s_cyc;
        int d_cyc;
        push(ADDR_W'(12'h555), DATA_W'(8'hAA), "R1");
        push(ADDR_W'(12'h2AA), DATA_W'(8'h55), "R1");
        push(a, DATA_W'(8'h25), "R2");
        push(a, DATA_W'(n - 1), "R2");
        for (int i = 0; i < n; i++) push(a + ADDR_W'(i), wgen(seed, i), "R3");
        push(a + ADDR_W'(n - 1), DATA_W'(8'h29), "R4");
        @(negedge clk);
        reset_mon();
        start = 1'b1; start_addr = a; word_count = CNT_W'(n); s_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        d_cyc = -1;
        fork
            feed(n, gap, seed);
            if (poke) begin
                repeat (5) @(negedge clk);
                start = 1'b1; start_addr = 24'h000380; word_count = CNT_W'(2);
                @(negedge clk);
                start = 1'b0;
            end
            begin
                int t;
                t = 0;
                while (!done && t < 2000) begin @(negedge clk); t++; end
                d_cyc = cyc;
                chk(done && busy, "R8", "done with busy", longint'({done, busy}), 3);
                @(negedge clk);
                chk(!busy && !done, "R8", "idle after done", longint'({done, busy}), 0);
            end
        join
        chk(exp_q.size() == 0, "R4", "writes missing", exp_q.size(), 0);
        chk(first_we_cyc == s_cyc + 1, "R5", "first write latency", first_we_cyc - s_cyc, 1);
        if (gap == 0) begin
            chk(we_cycles == (n + 5) * WR_CYC, "R5", "strobe cycles", we_cycles, (n + 5) * WR_CYC);
            chk(d_cyc - first_we_cyc == (n + 5) * WR_CYC, "R5", "back-to-back span",
                d_cyc - first_we_cyc, (n + 5) * WR_CYC);
        end else begin
            chk(we_cycles == (n + 5) * WR_CYC, "R6", "strobe cycles with stalls",
                we_cycles, (n + 5) * WR_CYC);
        end
        exp_q.delete();
        tag_q.delete();
    endtask

    task automatic run_reject(input logic [ADDR_W-1:0] a, input int n);
        int s_cyc;
        @(negedge clk);
        reset_mon();
        start = 1'b1; start_addr = a; word_count = CNT_W'(n); s_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk(err_cnt == 1, "R7", "err pulse count", err_cnt, 1);
        chk(err_cyc == s_cyc + 1, "R7", "err timing", err_cyc - s_cyc, 1);
        chk(we_cycles == 0, "R7", "no bus writes on reject", we_cycles, 0);
        chk(!busy, "R7", "idle after reject", longint'(busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R8", "watchdog expired", cyc, 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({busy, bus_we, data_ready, done, err} == 5'b0, "R10", "outputs in reset",
            longint'({busy, bus_we, data_ready, done, err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, bus_we, data_ready, done, err} == 5'b0, "R10", "outputs after reset",
            longint'({busy, bus_we, data_ready, done, err}), 0);

        run_seq(24'h000100, 4, 0, 1'b0, 1);   // R1 R2 R3 R4 R5 basic
        run_seq(24'h00011F, 1, 0, 1'b0, 2);   // single word at last window offset
        run_seq(24'h000200, 32, 0, 1'b0, 3);  // full window
        run_seq(24'h000043, 5, 3, 1'b0, 4);   // R6 stalled stream
        run_seq(24'h0000A0, 4, 0, 1'b1, 5);   // R9 start while busy
        run_seq(24'h00011D, 3, 0, 1'b0, 6);   // ends exactly on window edge
        run_reject(24'h000100, 0);            // R7 zero count
        run_reject(24'h000100, 33);           // R7 count too large
        run_reject(24'h00011E, 3);            // R7 window crossing

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule